// File: doc/BRIEF.md
# Register-File ADD Execution Unit

This block is the execute slice of a small 8-bit load/store core, reduced to one operation: adding one register to another. It holds thirty-two 8-bit general registers and an 8-bit status register. When the valid strobe is high, the block decodes the 16-bit instruction word. If the word is an ADD, the block reads both operand registers, forms their sum, and on the same clock edge writes the sum back to the first operand register and loads the arithmetic flags into the status register.

A debug port lets a host read any register and the status register without a clock. The same port can also write any register on a clock edge. This write path is the only way to load operand values, because the block executes no other instruction. Fetch, program storage, other opcodes, interrupts and the stack are all outside this block.

Top module: `rf_add_unit`

## Requirements
- R1: While reset is asserted, and afterwards until something is written, all 32 registers and the status register read as zero.
- R2: The block accepts a word as ADD only when bits 15..10 equal 6'b000011. Bits 9..5 select the destination and first operand (Rd), and bits 4..0 select the second operand (Rr). For example, 16'h0EEB adds R11 into R23.
- R3: A valid ADD writes (Rd + Rr) mod 256 into Rd at the clock edge that samples it. Rr keeps its value when it is a different register from Rd.
- R4: Status bit 0 (C) is the carry out of bit 7. Status bit 5 (H) is the carry out of bit 3.
- R5: Status bit 3 (V) is set when the two operands have the same sign and the sign of the result differs from it. Status bit 2 (N) is bit 7 of the result. Status bit 1 (Z) is set when the result is 8'h00.
- R6: Status bit 4 (S) equals N XOR V.
- R7: An ADD leaves status bits 7 and 6 unchanged. Since reset clears them and nothing else writes them, they stay 0.
- R8: When Rd equals Rr, the result is twice that register's value, and the flags are computed with the value used as both operands.
- R9: A word with a different opcode and the valid strobe high, or any word with the strobe low, changes no register and no status bit.
- R10: `dbg_data_o` shows the register selected by `dbg_idx_i` without a clock. When `dbg_we_i` is high, `dbg_wdata_i` is written to that register at the clock edge. If the debug write and an ADD target the same register in one cycle, the debug data wins, and the ADD still updates the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 16 | Instruction word |
| dbg_idx_i | input | 5 | Debug register index (read and write) |
| dbg_we_i | input | 1 | Debug write enable |
| dbg_wdata_i | input | 8 | Debug write data |
| dbg_data_o | output | 8 | Selected register contents |
| sreg_o | output | 8 | Status register |

## Verification
Every cycle, the assertions check several properties. The status register holds still when no ADD is accepted. Bits 7 and 6 stay zero. S always matches N XOR V. V never rises for operands of opposite sign. Every write lands in the addressed register on the next cycle. 16'h0EEB always decodes to R23 and R11. Only the bench's scenarios can show that the arithmetic itself is right, because that needs a reference computation. The bench sweeps every first-operand value against a spread of second operands that includes the sign and nibble boundaries. It also checks the same-register doubling case, rejected opcodes, and the write collision on one register.

// File: rtl/rf_add_pkg.sv
package rf_add_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned NR = 32;
  localparam int unsigned IW = $clog2(NR);
  localparam int unsigned SW = 8;

  localparam logic [5:0] OP_ADD = 6'b000011;

  // status bit positions
  localparam int unsigned FLG_C = 0;
  localparam int unsigned FLG_Z = 1;
  localparam int unsigned FLG_N = 2;
  localparam int unsigned FLG_V = 3;
  localparam int unsigned FLG_S = 4;
  localparam int unsigned FLG_H = 5;
  localparam int unsigned FLG_T = 6;
  localparam int unsigned FLG_I = 7;

  typedef struct packed {
    logic          is_add;
    logic [IW-1:0] rd;
    logic [IW-1:0] rr;
  } dec_t;
endpackage

// File: rtl/rf_add_decode.sv
module rf_add_decode
  import rf_add_pkg::*;
(
  input  logic [15:0] instr_i,
  output dec_t        dec_o
);
  always_comb begin
    dec_o.is_add = (instr_i[15:10] == OP_ADD);
    dec_o.rd     = instr_i[9:5];
    dec_o.rr     = instr_i[4:0];
  end
endmodule

// File: rtl/rf_add_alu.sv
module rf_add_alu #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              h_o,
  output logic              v_o,
  output logic              n_o,
  output logic              z_o,
  output logic              s_o
);
  localparam int unsigned MSB = DATA_W - 1;
  localparam int unsigned HW  = DATA_W / 2;

  logic [DATA_W:0] sum_full;
  logic [HW:0]     sum_half;

  always_comb begin
    sum_full = {1'b0, a_i} + {1'b0, b_i};
    sum_half = {1'b0, a_i[HW-1:0]} + {1'b0, b_i[HW-1:0]};
    res_o    = sum_full[MSB:0];
    c_o      = sum_full[DATA_W];
    h_o      = sum_half[HW];
    v_o      = (a_i[MSB] == b_i[MSB]) && (res_o[MSB] != a_i[MSB]);
    n_o      = res_o[MSB];
    z_o      = (res_o == '0);
    s_o      = n_o ^ v_o;
  end
endmodule

// File: rtl/rf_add_regfile.sv
module rf_add_regfile #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NREGS  = 32,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              add_we_i,
  input  logic [IDX_W-1:0]  add_idx_i,
  input  logic [DATA_W-1:0] add_data_i,
  input  logic              dbg_we_i,
  input  logic [IDX_W-1:0]  dbg_idx_i,
  input  logic [DATA_W-1:0] dbg_wdata_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [IDX_W-1:0]  rr_idx_i,
  output logic [DATA_W-1:0] rr_data_o,
  output logic [DATA_W-1:0] dbg_data_o
);
  logic [DATA_W-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    regs_q[g] <= '0;
      else if (dbg_we_i && dbg_idx_i == IDX_W'(g))    regs_q[g] <= dbg_wdata_i;
      else if (add_we_i && add_idx_i == IDX_W'(g))    regs_q[g] <= add_data_i;
    end
  end

  assign rd_data_o  = regs_q[rd_idx_i];
  assign rr_data_o  = regs_q[rr_idx_i];
  assign dbg_data_o = regs_q[dbg_idx_i];

  p_dbg_write_lands_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_we_i |=> regs_q[$past(dbg_idx_i)] == $past(dbg_wdata_i));

  p_add_write_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_we_i && !(dbg_we_i && dbg_idx_i == add_idx_i))
      |=> regs_q[$past(add_idx_i)] == $past(add_data_i));
endmodule

// File: rtl/rf_add_unit.sv
module rf_add_unit
  import rf_add_pkg::*;
#(
  parameter int unsigned DATA_W = rf_add_pkg::DW,
  parameter int unsigned NREGS  = rf_add_pkg::NR,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [15:0]       instr_i,
  input  logic [IDX_W-1:0]  dbg_idx_i,
  input  logic              dbg_we_i,
  input  logic [DATA_W-1:0] dbg_wdata_i,
  output logic [DATA_W-1:0] dbg_data_o,
  output logic [SW-1:0]     sreg_o
);
  dec_t              dec;
  logic              add_go;
  logic [DATA_W-1:0] opa, opb, res;
  logic              fc, fh, fv, fn, fz, fs;
  logic [SW-1:0]     sreg_q, sreg_d;

  rf_add_decode i_dec (.instr_i(instr_i), .dec_o(dec));

  assign add_go = valid_i && dec.is_add;

  rf_add_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) i_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .add_we_i   (add_go),
    .add_idx_i  (dec.rd),
    .add_data_i (res),
    .dbg_we_i   (dbg_we_i),
    .dbg_idx_i  (dbg_idx_i),
    .dbg_wdata_i(dbg_wdata_i),
    .rd_idx_i   (dec.rd),
    .rd_data_o  (opa),
    .rr_idx_i   (dec.rr),
    .rr_data_o  (opb),
    .dbg_data_o (dbg_data_o)
  );

  rf_add_alu #(.DATA_W(DATA_W)) i_alu (
    .a_i(opa), .b_i(opb), .res_o(res),
    .c_o(fc), .h_o(fh), .v_o(fv), .n_o(fn), .z_o(fz), .s_o(fs)
  );

  // I and T pass through untouched
  always_comb begin
    sreg_d        = sreg_q;
    sreg_d[FLG_C] = fc;
    sreg_d[FLG_Z] = fz;
    sreg_d[FLG_N] = fn;
    sreg_d[FLG_V] = fv;
    sreg_d[FLG_S] = fs;
    sreg_d[FLG_H] = fh;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sreg_q <= '0;
    else if (add_go) sreg_q <= sreg_d;
  end

  assign sreg_o = sreg_q;

  p_sreg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !add_go |=> $stable(sreg_q));

  p_it_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sreg_q[FLG_I] == 1'b0 && sreg_q[FLG_T] == 1'b0);

  p_sign_rule_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sreg_q[FLG_S] == (sreg_q[FLG_N] ^ sreg_q[FLG_V]));

  p_ovf_same_sign_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_go && opa[DATA_W-1] != opb[DATA_W-1]) |-> !fv);

  p_decode_0eeb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i == 16'h0EEB) |-> (dec.is_add && dec.rd == IDX_W'(23) && dec.rr == IDX_W'(11)));
endmodule

// File: tb/test_rf_add_unit.sv
`timescale 1ns/1ps
module test_rf_add_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] instr = '0;
  logic [4:0]  dbg_idx = '0;
  logic        dbg_we = 1'b0;
  logic [7:0]  dbg_wdata = '0;
  logic [7:0]  dbg_data;
  logic [7:0]  sreg;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rf_add_unit i_rf_add_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
    .dbg_idx_i(dbg_idx), .dbg_we_i(dbg_we), .dbg_wdata_i(dbg_wdata),
    .dbg_data_o(dbg_data), .sreg_o(sreg)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // tasks are entered and left at a falling edge
  task automatic dwrite(input logic [4:0] idx, input logic [7:0] val);
    dbg_we = 1'b1; dbg_idx = idx; dbg_wdata = val;
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic exec(input logic [15:0] word, input logic v);
    valid = v; instr = word;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic dread(input logic [4:0] idx, output logic [7:0] val);
    dbg_idx = idx;
    #0.5;
    val = dbg_data;
  endtask

  function automatic logic [7:0] exp_sreg(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s9;
    logic [4:0] h5;
    logic v, n, z;
    s9 = {1'b0, a} + {1'b0, b};
    h5 = {1'b0, a[3:0]} + {1'b0, b[3:0]};
    v  = (a[7] == b[7]) && (s9[7] != a[7]);
    n  = s9[7];
    z  = (s9[7:0] == 8'h00);
    return {2'b00, h5[4], n ^ v, v, n, z, s9[8]};
  endfunction

  function automatic logic [15:0] add_word(input logic [4:0] rd, input logic [4:0] rr);
    return {6'b000011, rd, rr};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    #12;
    // R1: reset state, reset still asserted
    for (int i = 0; i < 32; i++) begin
      dread(5'(i), r);
      chk("R1 reg under reset", r, 8'h00);
    end
    chk("R1 sreg under reset", sreg, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      dread(5'(i), r);
      chk("R1 reg after reset", r, 8'h00);
    end

    // R2: 0x0EEB adds R11 into R23
    dwrite(5'd23, 8'h3C);
    dwrite(5'd11, 8'hC4);
    exec(16'h0EEB, 1'b1);
    dread(5'd23, r); chk("R2 0x0EEB sum in R23", r, 8'h00);
    dread(5'd11, r); chk("R2 R11 untouched", r, 8'hC4);
    chk("R4 R5 0x0EEB flags", sreg, 8'h23);

    // R9: rejected opcode and strobe low
    dwrite(5'd4, 8'h11);
    dwrite(5'd9, 8'h22);
    exec({6'b000111, 5'd4, 5'd9}, 1'b1);
    dread(5'd4, r); chk("R9 other opcode reg", r, 8'h11);
    chk("R9 other opcode sreg", sreg, 8'h23);
    exec({6'b000010, 5'd4, 5'd9}, 1'b1);
    dread(5'd4, r); chk("R9 near opcode reg", r, 8'h11);
    exec(add_word(5'd4, 5'd9), 1'b0);
    dread(5'd4, r); chk("R9 strobe low reg", r, 8'h11);
    chk("R9 strobe low sreg", sreg, 8'h23);

    // R10: debug write beats ADD on same register, status still updated
    dbg_we = 1'b1; dbg_idx = 5'd4; dbg_wdata = 8'h77;
    exec(add_word(5'd4, 5'd9), 1'b1);
    dbg_we = 1'b0;
    dread(5'd4, r); chk("R10 debug wins", r, 8'h77);
    chk("R10 status from ADD", sreg, 8'h00);

    // R8: same register doubles
    for (int a = 0; a < 256; a += 3) begin
      dwrite(5'd5, 8'(a));
      exec(add_word(5'd5, 5'd5), 1'b1);
      dread(5'd5, r);
      chk("R8 doubled value", r, 8'(a + a));
      chk("R8 doubled flags", sreg, exp_sreg(8'(a), 8'(a)));
    end

    // R3..R7: first operand exhaustive, second spread plus boundaries
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 56; k++) begin
        logic [7:0] b;
        logic [4:0] rd, rr;
        case (k)
          52: b = 8'h80;
          53: b = 8'h7F;
          54: b = 8'h0F;
          55: b = 8'h01;
          default: b = 8'(k * 5);
        endcase
        rd = 5'((a * 7 + k) % 32);
        rr = 5'((int'(rd) + 1 + (k % 31)) % 32);
        dwrite(rd, 8'(a));
        dwrite(rr, b);
        exec(add_word(rd, rr), 1'b1);
        dread(rd, r);
        chk("R3 sum", r, 8'(a) + b);
        chk("R4 R5 R6 R7 status", sreg, exp_sreg(8'(a), b));
        if (k == 0) begin
          dread(rr, r);
          chk("R3 Rr kept", r, b);
        end
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule